// File: doc/BRIEF.md
# Receive Link-Recovery Reset Sequencer

This controller holds the receive digital reset of one serial transceiver channel. It releases that reset only after the channel has shown that it can recover data again. It also steps the clock-data-recovery lock-mode select between lock-to-reference and lock-to-data. Bring-up after power-on is covered. The controller also re-enters reset whenever the link is lost at run time. A lost link can be a missing reference clock, an unplugged cable or a far end that has gone quiet.

The `AUTO_MODE` parameter picks one of two recovery styles.

- **Automatic mode.** The recovery circuit changes lock mode on its own. The controller qualifies the frequency-lock status with a continuous-high timer. A datapath error strobe gives a fixed reset pulse two cycles long.
- **Manual mode.** The controller forces lock-to-reference and waits for the receive PLL to lock. It then waits for signal detect, switches to lock-to-data, and holds the reset for a second wait time.

All wait times are counted in parallel-clock cycles. The four status inputs each pass through a two-flop synchronizer. The error strobe comes from logic on the same clock and is used directly.

Top module: `rx_link_reset_seq`

## Requirements
- R1: While the synchronized transmit PLL lock is low, the controller sits in state code 0 (waiting for the reference clock) with the receive reset asserted. Once the lock returns, the whole sequence for the selected mode starts again from the beginning.
- R2: In automatic mode, the receive reset is asserted in the cycle after a low synchronized frequency-lock is seen, whatever the current state.
- R3: In automatic mode, the receive reset is released only after two conditions hold. Synchronized frequency-lock has been high for `LTD_AUTO_CYC` consecutive cycles. Synchronized transmit lock has been high for `LTD_AUTO_CYC`+1 consecutive cycles. A single low cycle restarts the count.
- R4: In automatic mode, `lock_to_data_o` stays at 0 (lock-to-reference, no override) at all times.
- R5: In automatic mode, an error strobe seen while the channel is ready (with both locks high) gives a receive reset exactly 2 cycles long, starting at the next clock edge. An error strobe at any other time has no effect.
- R6: In manual mode, a dead link while running forces `lock_to_data_o` to 0 and asserts the reset at the next edge. A dead link is a low synchronized signal detect or an error strobe. The controller then waits again for the receive PLL to lock.
- R7: In manual mode, the controller first waits for receive PLL lock, then for signal detect. Only then does it set `lock_to_data_o` to 1. It holds the reset for `LTD_MAN_CYC` further cycles and then releases it.
- R8: After power-on reset, `rx_dig_rst_o`=1, `lock_to_data_o`=0, `ready_o`=0 and `state_o`=0.
- R9: `ready_o` is 1 exactly when the receive reset is released and `state_o` is 6 (running). State codes: 0 wait reference clock, 1 qualify lock, 2 error pulse, 3 wait receive PLL, 4 wait signal, 5 lock-to-data wait, 6 running.
- R10: A status input change reaches the outputs after three clock edges: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pll_lock_i | input | 1 | Transmit PLL lock (asynchronous) |
| rx_pll_lock_i | input | 1 | Receive PLL lock (asynchronous) |
| freq_lock_i | input | 1 | Recovery-circuit frequency-lock status (asynchronous) |
| sig_det_i | input | 1 | Receive signal detect (asynchronous) |
| err_stb_i | input | 1 | Datapath error strobe, synchronous to clk |
| rx_dig_rst_o | output | 1 | Receive digital reset, active high |
| lock_to_data_o | output | 1 | Lock-mode select: 1 lock-to-data, 0 lock-to-reference |
| ready_o | output | 1 | Channel running with the reset released |
| state_o | output | 3 | Current state code for debug |

## Verification
Two instances, one in each mode, are driven with the same inputs.

Directed runs cover three cases:
- A clean bring-up, which separates the exact end of each qualification count from an off-by-one.
- A frequency-lock glitch in the middle of qualification, which shows whether the count restarts or only pauses.
- A reference-clock drop, which shows the synchronizer delay.

A lone error strobe while running shows the exact two-cycle pulse and that strobes are ignored at other times. Long random runs then toggle each status input at its own rate. This mixes lock flicker, signal loss and error strobes across every state, and an independent streak-count model checks each cycle's outputs.

// File: rtl/rxrst_pkg.sv
`timescale 1ns/1ps
package rxrst_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_REF  = 3'd0,
    ST_QUAL      = 3'd1,
    ST_ERR_PULSE = 3'd2,
    ST_WAIT_RXPL = 3'd3,
    ST_WAIT_SIG  = 3'd4,
    ST_LTD_WAIT  = 3'd5,
    ST_RUN       = 3'd6
  } rxrst_state_e;

  localparam int unsigned ERR_PULSE_CYC = 2;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rxrst_sync.sv
`timescale 1ns/1ps
module rxrst_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/rxrst_timer.sv
`timescale 1ns/1ps
module rxrst_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == (lim_i - 1'b1));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < (lim_i - 1'b1)));

endmodule

// File: rtl/rxrst_fsm.sv
`timescale 1ns/1ps
module rxrst_fsm
  import rxrst_pkg::*;
#(
  parameter bit          AUTO_MODE    = 1'b1,
  parameter int unsigned LTD_AUTO_CYC = 8,
  parameter int unsigned LTD_MAN_CYC  = 5,
  parameter int unsigned CW           = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_ok_i,
  input  logic          rxpll_ok_i,
  input  logic          flock_i,
  input  logic          sigdet_i,
  input  logic          err_i,
  input  logic          cnt_done_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic [CW-1:0] cnt_lim_o,
  output rxrst_state_e  state_o
);

  localparam logic [CW-1:0] LIM_AUTO = CW'(LTD_AUTO_CYC);
  localparam logic [CW-1:0] LIM_MAN  = CW'(LTD_MAN_CYC);
  localparam logic [CW-1:0] LIM_ERR  = CW'(ERR_PULSE_CYC);

  rxrst_state_e state_q;
  rxrst_state_e state_d;

  always_comb begin
    case (state_q)
      ST_ERR_PULSE: cnt_lim_o = LIM_ERR;
      ST_LTD_WAIT:  cnt_lim_o = LIM_MAN;
      default:      cnt_lim_o = LIM_AUTO;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b1;
    cnt_en_o  = 1'b0;
    if (!tx_ok_i) begin
      state_d = ST_WAIT_REF;
    end else begin
      case (state_q)
        ST_WAIT_REF: state_d = AUTO_MODE ? ST_QUAL : ST_WAIT_RXPL;
        ST_QUAL: begin
          if (flock_i) begin
            if (cnt_done_i) state_d = ST_RUN;
            else begin
              cnt_clr_o = 1'b0;
              cnt_en_o  = 1'b1;
            end
          end
        end
        ST_ERR_PULSE: begin
          if (!flock_i)        state_d = ST_QUAL;
          else if (cnt_done_i) state_d = ST_RUN;
          else begin
            cnt_clr_o = 1'b0;
            cnt_en_o  = 1'b1;
          end
        end
        ST_WAIT_RXPL: if (rxpll_ok_i) state_d = ST_WAIT_SIG;
        ST_WAIT_SIG:  if (sigdet_i)   state_d = ST_LTD_WAIT;
        ST_LTD_WAIT: begin
          if (cnt_done_i) state_d = ST_RUN;
          else begin
            cnt_clr_o = 1'b0;
            cnt_en_o  = 1'b1;
          end
        end
        ST_RUN: begin
          if (AUTO_MODE) begin
            if (!flock_i)   state_d = ST_QUAL;
            else if (err_i) state_d = ST_ERR_PULSE;
          end else if (!sigdet_i || err_i) begin
            state_d = ST_WAIT_RXPL;
          end
        end
        default: state_d = ST_WAIT_REF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_REF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  refloss_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ok_i |=> (state_q == ST_WAIT_REF));

  // R2
  flock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_MODE && !flock_i) |=> (state_q != ST_RUN));

  // R5
  err_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_MODE && state_q == ST_RUN && tx_ok_i && flock_i && err_i)
      |=> (state_q != ST_RUN) ##1 (state_q != ST_RUN));

endmodule

// File: rtl/rx_link_reset_seq.sv
`timescale 1ns/1ps
module rx_link_reset_seq
  import rxrst_pkg::*;
#(
  parameter bit          AUTO_MODE    = 1'b1,
  parameter int unsigned LTD_AUTO_CYC = 8,
  parameter int unsigned LTD_MAN_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_pll_lock_i,
  input  logic       rx_pll_lock_i,
  input  logic       freq_lock_i,
  input  logic       sig_det_i,
  input  logic       err_stb_i,
  output logic       rx_dig_rst_o,
  output logic       lock_to_data_o,
  output logic       ready_o,
  output logic [2:0] state_o
);

  localparam int unsigned MAX_LIM = max3(LTD_AUTO_CYC, LTD_MAN_CYC, ERR_PULSE_CYC);
  localparam int unsigned CW      = $clog2(MAX_LIM + 1);
  localparam int unsigned NSTAT   = 4;

  logic [NSTAT-1:0] stat_raw;
  logic [NSTAT-1:0] stat_s;
  logic             cnt_clr;
  logic             cnt_en;
  logic             cnt_done;
  logic [CW-1:0]    cnt_lim;
  rxrst_state_e     state;

  assign stat_raw = {sig_det_i, freq_lock_i, rx_pll_lock_i, tx_pll_lock_i};

  rxrst_sync #(.WIDTH(NSTAT)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stat_raw),
    .sync_o  (stat_s)
  );

  rxrst_timer #(.CW(CW)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .lim_i  (cnt_lim),
    .done_o (cnt_done)
  );

  rxrst_fsm #(
    .AUTO_MODE    (AUTO_MODE),
    .LTD_AUTO_CYC (LTD_AUTO_CYC),
    .LTD_MAN_CYC  (LTD_MAN_CYC),
    .CW           (CW)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ok_i    (stat_s[0]),
    .rxpll_ok_i (stat_s[1]),
    .flock_i    (stat_s[2]),
    .sigdet_i   (stat_s[3]),
    .err_i      (err_stb_i),
    .cnt_done_i (cnt_done),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .cnt_lim_o  (cnt_lim),
    .state_o    (state)
  );

  assign ready_o        = (state == ST_RUN);
  assign rx_dig_rst_o   = ~ready_o;
  assign lock_to_data_o = !AUTO_MODE && ((state == ST_LTD_WAIT) || (state == ST_RUN));
  assign state_o        = state;

  // R6
  dead_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!AUTO_MODE && ready_o && stat_s[0] && (!stat_s[3] || err_stb_i))
      |=> (rx_dig_rst_o && !lock_to_data_o));

  // R7
  ltd_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!AUTO_MODE && $fell(rx_dig_rst_o)) |-> lock_to_data_o);

  // R4
  auto_no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_MODE && $rose(ready_o)) |-> !lock_to_data_o);

endmodule

// File: tb/rx_link_reset_seq_tb_top.sv
`timescale 1ns/1ps
module rx_link_reset_seq_tb_top;

  localparam int unsigned NA = 8;
  localparam int unsigned NM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b0, rxp = 1'b0, fl = 1'b0, sg = 1'b0, er = 1'b0;

  logic       a_rst, a_ltd, a_rdy;
  logic [2:0] a_st;
  logic       m_rst, m_ltd, m_rdy;
  logic [2:0] m_st;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  rx_link_reset_seq #(.AUTO_MODE(1'b1), .LTD_AUTO_CYC(NA), .LTD_MAN_CYC(NM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_pll_lock_i(tx), .rx_pll_lock_i(rxp),
    .freq_lock_i(fl), .sig_det_i(sg), .err_stb_i(er),
    .rx_dig_rst_o(a_rst), .lock_to_data_o(a_ltd), .ready_o(a_rdy), .state_o(a_st));

  rx_link_reset_seq #(.AUTO_MODE(1'b0), .LTD_AUTO_CYC(NA), .LTD_MAN_CYC(NM)) dut_man_i (
    .clk(clk), .rst_n(rst_n), .tx_pll_lock_i(tx), .rx_pll_lock_i(rxp),
    .freq_lock_i(fl), .sig_det_i(sg), .err_stb_i(er),
    .rx_dig_rst_o(m_rst), .lock_to_data_o(m_ltd), .ready_o(m_rdy), .state_o(m_st));

  // reference model: synchronizers plus streak counters and a manual phase
  logic tx1, tx2, rx1, rx2, fl1, fl2, sg1, sg2;
  int   tx_run, fl_run, err_left, ph, mcnt;

  function automatic bit auto_ready_exp();
    return (tx_run >= NA + 1) && (fl_run >= NA) && (err_left == 0);
  endfunction

  function automatic string auto_tag();
    if (tx_run <= NA)  return "R1";
    if (err_left != 0) return "R5";
    if (fl_run == 0)   return "R2";
    return "R3";
  endfunction

  function automatic string man_tag();
    if (ph == 0) return "R1";
    if (ph < 3)  return "R6";
    return "R7";
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx1 <= 0; tx2 <= 0; rx1 <= 0; rx2 <= 0; fl1 <= 0; fl2 <= 0; sg1 <= 0; sg2 <= 0;
      tx_run <= 0; fl_run <= 0; err_left <= 0; ph <= 0; mcnt <= 0;
    end else begin
      tx1 <= tx; tx2 <= tx1; rx1 <= rxp; rx2 <= rx1;
      fl1 <= fl; fl2 <= fl1; sg1 <= sg;  sg2 <= sg1;
      tx_run <= tx2 ? ((tx_run >= 255) ? 255 : tx_run + 1) : 0;
      fl_run <= fl2 ? ((fl_run >= 255) ? 255 : fl_run + 1) : 0;
      if (auto_ready_exp() && tx2 && fl2 && er) err_left <= 2;
      else if (err_left != 0)                    err_left <= err_left - 1;
      if (!tx2) ph <= 0;
      else begin
        case (ph)
          0: ph <= 1;
          1: if (rx2) ph <= 2;
          2: if (sg2) begin ph <= 3; mcnt <= 0; end
          3: if (mcnt == NM - 1) ph <= 4; else mcnt <= mcnt + 1;
          default: if (!sg2 || er) ph <= 1;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act,
                     input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_model();
    bit ar;
    bit mr;
    ar = auto_ready_exp();
    mr = (ph == 4);
    chk(a_rst == !ar, auto_tag(), "auto rx_dig_rst", a_rst, !ar);
    chk(a_rdy == ar && (a_st == 3'd6) == ar, "R9", "auto ready/state", a_rdy, ar);
    chk(a_ltd == 1'b0, "R4", "auto lock_to_data", a_ltd, 0);
    chk(m_rst == !mr, man_tag(), "manual rx_dig_rst", m_rst, !mr);
    chk(m_ltd == (ph >= 3), man_tag(), "manual lock_to_data", m_ltd, ph >= 3);
    chk(m_rdy == mr, "R9", "manual ready", m_rdy, mr);
  endtask

  task automatic cyc(input bit t, input bit r, input bit f, input bit s, input bit e);
    @(negedge clk);
    check_model();
    tx = t; rxp = r; fl = f; sg = s; er = e;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 power-on state
    chk(a_rst == 1 && a_ltd == 0 && a_rdy == 0 && a_st == 0, "R8", "auto reset state", a_st, 0);
    chk(m_rst == 1 && m_ltd == 0 && m_rdy == 0 && m_st == 0, "R8", "manual reset state", m_st, 0);
    rst_n = 1'b1;

    // clean bring-up (R3, R7)
    repeat (4) cyc(0, 0, 0, 0, 0);
    repeat (30) cyc(1, 1, 1, 1, 0);
    chk(a_rdy == 1, "R3", "auto ready after bring-up", a_rdy, 1);
    chk(m_rdy == 1 && m_ltd == 1, "R7", "manual running in lock-to-data", m_ltd, 1);

    // frequency-lock glitch during qualification (R2, R3)
    cyc(1, 1, 0, 1, 0);
    repeat (6) cyc(1, 1, 1, 1, 0);
    cyc(1, 1, 0, 1, 0);
    repeat (NA + 4) cyc(1, 1, 1, 1, 0);
    chk(a_rdy == 1, "R3", "auto ready after glitch", a_rdy, 1);

    // lone error strobe (R5, R6)
    cyc(1, 1, 1, 1, 1);
    cyc(1, 1, 1, 1, 0);
    chk(a_rst == 1, "R5", "err pulse cycle 1", a_rst, 1);
    chk(m_rst == 1 && m_ltd == 0, "R6", "manual dead link on error", m_ltd, 0);
    cyc(1, 1, 1, 1, 0);
    chk(a_rst == 1, "R5", "err pulse cycle 2", a_rst, 1);
    cyc(1, 1, 1, 1, 0);
    chk(a_rst == 0, "R5", "err pulse ended", a_rst, 0);
    repeat (12) cyc(1, 1, 1, 1, 0);

    // reference loss and synchronizer delay (R10, R1)
    cyc(0, 1, 1, 1, 0);
    cyc(0, 1, 1, 1, 0);
    chk(a_rdy == 1, "R10", "no change after one edge", a_rdy, 1);
    cyc(0, 1, 1, 1, 0);
    chk(a_rdy == 1, "R10", "no change after two edges", a_rdy, 1);
    cyc(0, 1, 1, 1, 0);
    chk(a_rst == 1 && a_st == 0, "R10", "reset after three edges", a_st, 0);
    chk(m_st == 0 && m_ltd == 0, "R1", "manual back to wait reference", m_st, 0);
    repeat (30) cyc(1, 1, 1, 1, 0);

    // random stimulus
    for (int i = 0; i < 8000; i++) begin
      bit t, r, f, s, e;
      t = tx  ? ($urandom_range(299) != 0) : ($urandom_range(19) == 0);
      r = rxp ? ($urandom_range(199) != 0) : ($urandom_range(9) == 0);
      f = fl  ? ($urandom_range(59) != 0)  : ($urandom_range(29) == 0);
      s = sg  ? ($urandom_range(149) != 0) : ($urandom_range(14) == 0);
      e = ($urandom_range(79) == 0);
      cyc(t, r, f, s, e);
    end
    cyc(1, 1, 1, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule